// File: doc/BRIEF.md
# Integer Multiply-Divide Execution Unit

This unit does 32-bit integer multiplication and division for a processor core whose single-cycle ALU is a separate block. The issue stage presents an operation with a valid strobe, a 3-bit operation code, two operands and a destination tag. The issue is accepted on the first rising edge at which `issue_stall` is low. Each completed operation comes back as a one-cycle `res_valid` pulse with the result word, the tag it was issued with, and two error flags.

Multiplies flow through a three-stage pipeline, so a new one can be accepted every cycle. A divide runs on a serial restoring engine that handles one quotient bit per cycle, and it occupies the whole unit. While a multiply is still in flight, a divide is held at issue. While a divide is running, every new multiply or divide is held. The stall depends only on requests aimed at this unit. Instructions bound for the ALU are never held back by work in progress here.

Top module: `imd_unit`

## Requirements
- R1: The operation codes are 000 (low 32 bits of the product), 001 (high 32 bits of the signed product), 010 (high 32 bits of the unsigned product), 100 (signed quotient) and 101 (unsigned quotient). A multiply accepted in cycle N presents its result and tag in cycle N+3.
- R2: While no divide is running, multiplies are accepted on consecutive cycles with `issue_stall` low.
- R3: Only one divide runs at a time. An unsigned divide accepted in cycle N returns in cycle N+33, and a signed divide returns in cycle N+34.
- R4: A divide is held while an earlier multiply has not yet presented its result. It can be accepted, at the earliest, in the cycle in which the last such result appears.
- R5: While a divide is running, any new multiply or divide is held. The next one can be accepted, at the earliest, in the cycle in which the divide's result appears.
- R6: `issue_stall` is low whenever `issue_valid` is low, so ALU traffic is never held by this unit.
- R7: A signed quotient is truncated toward zero.
- R8: A divide by zero completes in the normal time, returns 0xFFFFFFFF and sets `res_div0`.
- R9: A signed divide of 0x80000000 by 0xFFFFFFFF returns 0x80000000 and sets `res_ovf`.
- R10: Results leave in issue order, at most one per cycle, and both flags are low for multiplies and for divides that do not hit R8 or R9.
- R11: During reset and directly after it, `res_valid` and `issue_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An operation is offered |
| issue_op | input | 3 | Operation code (R1) |
| issue_a | input | 32 | Multiplicand or dividend |
| issue_b | input | 32 | Multiplier or divisor |
| issue_tag | input | 5 | Destination tag |
| issue_stall | output | 1 | The offered operation is not accepted this cycle |
| res_valid | output | 1 | Result strobe |
| res_data | output | 32 | Product half or quotient |
| res_tag | output | 5 | Tag of the returning operation |
| res_div0 | output | 1 | Divisor was zero |
| res_ovf | output | 1 | Signed quotient overflowed |

## Verification
The multiply path gets a back-to-back burst that mixes all three product selections with operand pairs whose signs differ. A wrong stage count, a mixed-up signed and unsigned high half, or a product that lands on the wrong tag each shows up in this burst. Mixed sequences (multiply then divide, divide then multiply, divide then divide, signed and unsigned) measure the acceptance cycle against the exact cycle in which the blocking operation leaves the unit, so a stall that ends one cycle early or one cycle late is caught. The divide operands cover mixed signs, a zero divisor in both signednesses and the single overflowing pair. These separate truncation toward zero, the forced all-ones quotient and the overflow flag. While a divide is busy, the bench also probes with `issue_valid` low to confirm that the stall never reaches ALU traffic.

// File: rtl/imd_pkg.sv
package imd_pkg;
  typedef enum logic [2:0] {
    OP_MUL_LO = 3'b000,
    OP_MUL_HS = 3'b001,
    OP_MUL_HU = 3'b010,
    OP_DIV_S  = 3'b100,
    OP_DIV_U  = 3'b101
  } md_op_e;

  localparam int unsigned MUL_STAGES = 3;
endpackage

// File: rtl/imd_mulpipe.sv
module imd_mulpipe #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [1:0]       sel,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [TAG_W-1:0] tag,
  output logic             busy,
  output logic             out_v,
  output logic [XLEN-1:0]  out_data,
  output logic [TAG_W-1:0] out_tag
);
  localparam int PW = 2 * XLEN;

  // stage 1: extended operands
  logic             s1_v, s1_v_nx;
  logic [XLEN:0]    s1_a, s1_b;
  logic             s1_hi;
  logic [TAG_W-1:0] s1_tag;
  // stage 2: full product
  logic             s2_v, s2_v_nx;
  logic [PW-1:0]    s2_p;
  logic             s2_hi;
  logic [TAG_W-1:0] s2_tag;
  logic [PW-1:0]    prod;
  logic             sx;
  logic             o_v_nx;

  always_comb begin
    sx      = (sel == 2'b01);
    s1_v_nx = go;
    s2_v_nx = s1_v;
    o_v_nx  = s2_v;
    prod    = {{(XLEN-1){s1_a[XLEN]}}, s1_a} * {{(XLEN-1){s1_b[XLEN]}}, s1_b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      out_v <= 1'b0;
    end else begin
      s1_v  <= s1_v_nx;
      s2_v  <= s2_v_nx;
      out_v <= o_v_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      s1_a   <= {sx & a[XLEN-1], a};
      s1_b   <= {sx & b[XLEN-1], b};
      s1_hi  <= sel[0] | sel[1];
      s1_tag <= tag;
    end
    if (s1_v) begin
      s2_p   <= prod;
      s2_hi  <= s1_hi;
      s2_tag <= s1_tag;
    end
    if (s2_v) begin
      out_data <= s2_hi ? s2_p[PW-1:XLEN] : s2_p[XLEN-1:0];
      out_tag  <= s2_tag;
    end
  end

  assign busy = s1_v | s2_v;

  a_r1_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ##2 out_v);
endmodule

// File: rtl/imd_divider.sv
module imd_divider #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             sgn,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [TAG_W-1:0] tag,
  output logic             busy,
  output logic             out_v,
  output logic [XLEN-1:0]  out_q,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_dz,
  output logic             out_ovf
);
  localparam int CNT_W = $clog2(XLEN + 1);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  typedef enum logic [1:0] {D_IDLE, D_RUN, D_FIX} dstate_e;
  dstate_e          st, st_nx;

  logic [CNT_W-1:0] cnt;
  logic [XLEN-1:0]  rem, quo, dvs;
  logic [XLEN-1:0]  rem_nx, quo_nx;
  logic             neg, dz, ovf, sgn_r;
  logic [TAG_W-1:0] tag_r;
  logic [XLEN:0]    shifted, trial;
  logic             last, o_v_nx;
  logic [XLEN-1:0]  a_abs, b_abs;

  always_comb begin
    a_abs   = (sgn && a[XLEN-1]) ? (~a + 1'b1) : a;
    b_abs   = (sgn && b[XLEN-1]) ? (~b + 1'b1) : b;
    shifted = {rem, quo[XLEN-1]};
    trial   = shifted - {1'b0, dvs};
    if (!trial[XLEN]) begin
      rem_nx = trial[XLEN-1:0];
      quo_nx = {quo[XLEN-2:0], 1'b1};
    end else begin
      rem_nx = shifted[XLEN-1:0];
      quo_nx = {quo[XLEN-2:0], 1'b0};
    end
    last   = (st == D_RUN) && (cnt == CNT_W'(1));
    o_v_nx = (last && !sgn_r) || (st == D_FIX);
    st_nx  = st;
    case (st)
      D_IDLE:  if (go) st_nx = D_RUN;
      D_RUN:   if (last) st_nx = sgn_r ? D_FIX : D_IDLE;
      default: st_nx = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= D_IDLE;
      out_v <= 1'b0;
    end else begin
      st    <= st_nx;
      out_v <= o_v_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      rem   <= '0;
      quo   <= a_abs;
      dvs   <= b_abs;
      cnt   <= CNT_W'(XLEN);
      neg   <= sgn & (a[XLEN-1] ^ b[XLEN-1]);
      dz    <= (b == '0);
      ovf   <= sgn && (a == MOST_NEG) && (b == '1);
      sgn_r <= sgn;
      tag_r <= tag;
    end else if (st == D_RUN) begin
      rem <= rem_nx;
      quo <= quo_nx;
      cnt <= cnt - 1'b1;
    end
    if (o_v_nx) begin
      if (st == D_FIX)
        out_q <= dz ? '1 : (neg ? (~quo + 1'b1) : quo);
      else
        out_q <= quo_nx;
      out_tag <= tag_r;
      out_dz  <= dz;
      out_ovf <= ovf;
    end
  end

  assign busy = (st != D_IDLE);

  a_r3_one_divide: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);
  a_r8_zero_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && out_dz) |-> (out_q == '1));
  a_r9_ovf_value: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && out_ovf) |-> (out_q == MOST_NEG));
endmodule

// File: rtl/imd_unit.sv
module imd_unit
  import imd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [2:0]       issue_op,
  input  logic [XLEN-1:0]  issue_a,
  input  logic [XLEN-1:0]  issue_b,
  input  logic [TAG_W-1:0] issue_tag,
  output logic             issue_stall,
  output logic             res_valid,
  output logic [XLEN-1:0]  res_data,
  output logic [TAG_W-1:0] res_tag,
  output logic             res_div0,
  output logic             res_ovf
);
  logic             is_div, mul_go, div_go;
  logic             mul_busy, div_busy;
  logic             mul_v, div_v;
  logic [XLEN-1:0]  mul_d, div_d;
  logic [TAG_W-1:0] mul_t, div_t;
  logic             div_z, div_o;

  always_comb begin
    is_div      = issue_op[2];
    issue_stall = issue_valid && (div_busy || (is_div && mul_busy));
    mul_go      = issue_valid && !issue_stall && !is_div;
    div_go      = issue_valid && !issue_stall && is_div;
  end

  imd_mulpipe #(.XLEN(XLEN), .TAG_W(TAG_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .sel(issue_op[1:0]),
    .a(issue_a), .b(issue_b), .tag(issue_tag),
    .busy(mul_busy), .out_v(mul_v), .out_data(mul_d), .out_tag(mul_t)
  );

  imd_divider #(.XLEN(XLEN), .TAG_W(TAG_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .sgn(!issue_op[0]),
    .a(issue_a), .b(issue_b), .tag(issue_tag),
    .busy(div_busy), .out_v(div_v), .out_q(div_d), .out_tag(div_t),
    .out_dz(div_z), .out_ovf(div_o)
  );

  always_comb begin
    res_valid = mul_v | div_v;
    res_data  = div_v ? div_d : mul_d;
    res_tag   = div_v ? div_t : mul_t;
    res_div0  = div_v & div_z;
    res_ovf   = div_v & div_o;
  end

  a_r4_div_after_mul: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !mul_busy);
  a_r5_mul_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> !div_busy);
  a_r6_alu_free: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !issue_stall);
  a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(mul_v && div_v));
endmodule

// File: tb/imd_unit_test.sv
`timescale 1ns/100ps
module imd_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [2:0]  issue_op;
  logic [31:0] issue_a, issue_b;
  logic [4:0]  issue_tag;
  logic        issue_stall, res_valid, res_div0, res_ovf;
  logic [31:0] res_data;
  logic [4:0]  res_tag;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] d;
    logic [4:0]  t;
    logic        z;
    logic        o;
    int          due;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  imd_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_a(issue_a), .issue_b(issue_b), .issue_tag(issue_tag),
    .issue_stall(issue_stall), .res_valid(res_valid), .res_data(res_data),
    .res_tag(res_tag), .res_div0(res_div0), .res_ovf(res_ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic [31:0] a,
                                 input logic [31:0] b);
    exp_t e;
    logic [63:0] p;
    e.z = 1'b0; e.o = 1'b0;
    case (op)
      3'b000: begin p = {32'b0, a} * {32'b0, b}; e.d = p[31:0]; end
      3'b001: begin p = {{32{a[31]}}, a} * {{32{b[31]}}, b}; e.d = p[63:32]; end
      3'b010: begin p = {32'b0, a} * {32'b0, b}; e.d = p[63:32]; end
      default: begin
        if (b == 32'd0) begin
          e.d = 32'hFFFF_FFFF; e.z = 1'b1;
        end else if (op == 3'b100 && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
          e.d = 32'h8000_0000; e.o = 1'b1;
        end else if (op == 3'b100) begin
          e.d = $signed(a) / $signed(b);
        end else begin
          e.d = a / b;
        end
      end
    endcase
    return e;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] tag,
                       input string req, output int acc);
    exp_t e;
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op; issue_a = a; issue_b = b; issue_tag = tag;
    #1;
    while (issue_stall) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    @(posedge clk);
    #1 issue_valid = 1'b0;
    e = model(op, a, b);
    e.t = tag;
    e.req = req;
    e.due = acc + (op[2] ? (op[0] ? 33 : 34) : 3);
    sb.push_back(e);
  endtask

  // monitor: compare results in issue order
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10", "unexpected result", res_data, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(res_data == e.d, e.req, "data", res_data, e.d);
        chk(res_tag == e.t, e.req, "tag", res_tag, e.t);
        chk(cyc == e.due, e.req, "result cycle", cyc, e.due);
        chk(res_div0 == e.z && res_ovf == e.o, e.req, "flags R10",
            {res_div0, res_ovf}, {e.z, e.o});
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 100 && sb.size() != 0; i++) @(negedge clk);
    chk(sb.size() == 0, "R10", "missing results", sb.size(), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int a0, a1, a2, a3;
    rst_n = 1'b0; issue_valid = 1'b0; issue_op = '0;
    issue_a = '0; issue_b = '0; issue_tag = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R11", "res_valid in reset", res_valid, 0);
    chk(issue_stall == 1'b0, "R11", "stall in reset", issue_stall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0 && issue_stall == 1'b0, "R11", "after reset",
        {res_valid, issue_stall}, 0);

    // R1 / R2: back-to-back multiplies of every kind
    issue(3'b000, 32'h1234_5678, 32'h9ABC_DEF0, 5'd1, "R1", a0);
    issue(3'b001, 32'hFFFF_FFF9, 32'h0000_0003, 5'd2, "R1", a1);
    issue(3'b010, 32'hFFFF_FFF9, 32'h0000_0003, 5'd3, "R1", a2);
    issue(3'b001, 32'h8000_0000, 32'h8000_0000, 5'd4, "R2", a3);
    chk(a1 == a0 + 1 && a2 == a0 + 2 && a3 == a0 + 3, "R2", "consecutive accept",
        a3 - a0, 3);
    drain();

    // R4: divide right after multiplies
    issue(3'b000, 32'd7, 32'd9, 5'd5, "R4", a0);
    issue(3'b000, 32'd11, 32'd13, 5'd6, "R4", a1);
    issue(3'b101, 32'd1000, 32'd7, 5'd7, "R3", a2);
    chk(a2 == a1 + 3, "R4", "divide accept cycle", a2 - a1, 3);
    // R3: divide right after divide
    issue(3'b101, 32'hFFFF_FFFF, 32'd3, 5'd8, "R3", a3);
    chk(a3 == a2 + 33, "R3", "second divide accept", a3 - a2, 33);
    drain();

    // R5 / R6: signed divide then multiply; probe stall with no request
    issue(3'b100, 32'hFFFF_FFF9, 32'd2, 5'd9, "R7", a0);
    @(negedge clk); #1;
    chk(issue_stall == 1'b0, "R6", "stall with valid low during divide", issue_stall, 0);
    @(negedge clk); #1;
    chk(issue_stall == 1'b0, "R6", "stall with valid low, later", issue_stall, 0);
    issue(3'b000, 32'd3, 32'd5, 5'd10, "R5", a1);
    chk(a1 == a0 + 34, "R5", "multiply after signed divide", a1 - a0, 34);
    drain();

    // R7: truncation toward zero
    issue(3'b100, 32'd7, 32'hFFFF_FFFE, 5'd11, "R7", a0);
    issue(3'b100, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 5'd12, "R7", a1);
    // R8: divide by zero, both signednesses
    issue(3'b101, 32'd55, 32'd0, 5'd13, "R8", a2);
    issue(3'b100, 32'hFFFF_FFF0, 32'd0, 5'd14, "R8", a3);
    // R9: overflowing pair
    issue(3'b100, 32'h8000_0000, 32'hFFFF_FFFF, 5'd15, "R9", a0);
    // unsigned divide of the same bits: no overflow
    issue(3'b101, 32'h8000_0000, 32'hFFFF_FFFF, 5'd16, "R10", a1);
    drain();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule